// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bit PHY

This block is the slave-side physical layer for a shared open-drain wire on which every symbol is a low pulse, and the only thing that tells one symbol from another is how long the wire stays low. It samples the wire through a synchroniser and a short glitch filter. It times each low period in reference-clock cycles and hands the transaction layer one strobe per symbol, with a type code: Data 0, Data 1, Start, Attention or Reset.

The block also drives the wire. When the transaction layer wants a read bit to come back as 1, the block stretches the master's short request pulse by holding the wire low itself. When it wants the master's attention, it sends a long low pulse. That pulse starts either on an idle bus or right on top of a pulse that another device has just begun. Classification always uses the total low time seen on the wire, including the block's own drive, so a longer overlapping pulse always wins over a shorter one. All thresholds are parameters, given in microseconds and scaled by a cycles-per-microsecond parameter.

`line_in` must carry the resolved wire level, which includes this block's own pull-down. `drive_low` high enables the open-drain pull-down.

Top module: `pwbus_phy`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `drive_low`, `sym_valid` and `bus_idle` are all 0.
- R2: `bus_idle` is 1 only once the wire has been high for at least INACT_US. It is 0 throughout any low period that outlasts the filter.
- R3: A low period that started from an idle bus is classified by its total length L, and the code appears on `sym_type`. The classes are: L < BIT0_LIM_US gives code 0 (Data 0); L < BIT1_LIM_US gives code 1 (Data 1); L < START_LIM_US gives code 2 (Start); L < ATTN_LIM_US gives code 3 (Attention); a longer L gives code 4 (Reset).
- R4: A symbol other than a Reset caught while the wire is still low is reported by a one-cycle `sym_valid` pulse, which comes shortly after the wire rises. Two strobes never occur in consecutive cycles.
- R5: A low period shorter than GLITCH_US produces no strobe.
- R6: A low period that begins before the bus is idle produces no strobe, unless it reaches the Reset range.
- R7: Once a low period reaches RESET_US, a Reset strobe (code 4) is given while the wire is still low. This happens whether or not the bus was idle, and no further strobe is given when the wire is released.
- R8: If `rd_one` is 1 when a master pulse that starts from idle is detected, the block drives the wire low for exactly RD1_US. The drive starts within 9.6 µs of the master's falling edge, and the resulting symbol reports code 1.
- R9: If `rd_one` is 0 when a master pulse starts, the block does not drive the wire.
- R10: An `attn_req` pulse is held pending until the bus is idle. The block then drives the wire low for exactly ATTN_US, and the symbol reports code 3.
- R11: An Attention request raised just after a master pulse begins takes precedence over `rd_one`. The drive starts within 9.6 µs of the master's edge and lasts ATTN_US, and the symbol reports code 3.
- R12: A low glitch shorter than FILT_LEN clock cycles is removed by the input filter: it gives no strobe and does not clear `bus_idle`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Resolved wire level, 1 = high |
| rd_one | input | 1 | Answer the next master read pulse with a 1 |
| attn_req | input | 1 | One-cycle request to send an Attention pulse |
| drive_low | output | 1 | Open-drain pull-down enable, 1 = pull wire low |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_type | output | 3 | Symbol code: 0 Data 0, 1 Data 1, 2 Start, 3 Attention, 4 Reset |
| bus_idle | output | 1 | Wire has been high long enough to count as inactive |

## Verification
The hardest case to reach is an Attention that overlaps a pulse the master has already begun, with `rd_one` also asking for a read of 1. The bench starts a master pulse and raises `attn_req` one cycle later, while the filtered view of the wire still shows an idle bus. It then checks that the block's own drive starts inside the detect window, that its length is the Attention length rather than the read-1 length, and that the merged low period is reported as Attention. Pulses that start before the bus is idle are produced by leaving a high gap shorter than the inactive time between two master pulses.

// File: rtl/pwbus_pkg.sv
package pwbus_pkg;

    typedef enum logic [2:0] {
        SYM_D0    = 3'd0,
        SYM_D1    = 3'd1,
        SYM_START = 3'd2,
        SYM_ATTN  = 3'd3,
        SYM_RESET = 3'd4
    } sym_e;

endpackage

// File: rtl/pwbus_filt.sv
module pwbus_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o
);
    localparam int FW = $clog2(FILT_LEN + 1);
    localparam logic [FW-1:0] LAST = FW'(FILT_LEN - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          out;
        logic [FW-1:0] cnt;
    } filt_st_t;

    filt_st_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        if (q.sync[1] != q.out) begin
            if (q.cnt == LAST) begin
                d.out = q.sync[1];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.out  <= 1'b1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign lvl_o = q.out;

    // R12: the filtered level only moves to a value the synchronised input held for two cycles
    p_filt_min_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_o) |-> ($past(q.sync[1]) == lvl_o) && ($past(q.sync[1], 2) == lvl_o));

endmodule

// File: rtl/pwbus_rx.sv
module pwbus_rx
    import pwbus_pkg::*;
#(
    parameter int CW         = 17,
    parameter int INACT_CYC  = 2750,
    parameter int GLITCH_CYC = 2000,
    parameter int B0_CYC     = 6500,
    parameter int B1_CYC     = 15500,
    parameter int ST_CYC     = 33750,
    parameter int AT_CYC     = 72500,
    parameter int RST_CYC    = 88500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    output logic       sym_valid_o,
    output logic [2:0] sym_type_o,
    output logic       bus_idle_o,
    output logic       fall_start_o
);
    localparam logic [CW-1:0] INACT_L = CW'(INACT_CYC);
    localparam logic [CW-1:0] GL_L    = CW'(GLITCH_CYC);
    localparam logic [CW-1:0] B0_L    = CW'(B0_CYC);
    localparam logic [CW-1:0] B1_L    = CW'(B1_CYC);
    localparam logic [CW-1:0] ST_L    = CW'(ST_CYC);
    localparam logic [CW-1:0] AT_L    = CW'(AT_CYC);
    localparam logic [CW-1:0] RST_L   = CW'(RST_CYC);
    localparam logic [CW-1:0] RST_M1  = CW'(RST_CYC - 1);

    typedef struct packed {
        logic          lvl_prev;
        logic          armed;
        logic          vld;
        sym_e          typ;
        logic [CW-1:0] low_cnt;
        logic [CW-1:0] high_cnt;
    } rx_st_t;

    rx_st_t q, d;
    logic   fall, rise, idle;

    always_comb begin
        fall = q.lvl_prev & ~lvl_i;
        rise = ~q.lvl_prev & lvl_i;
        idle = (q.high_cnt >= INACT_L);

        d          = q;
        d.lvl_prev = lvl_i;
        d.vld      = 1'b0;

        if (lvl_i) begin
            if (q.high_cnt < INACT_L) d.high_cnt = q.high_cnt + 1'b1;
        end else begin
            d.high_cnt = '0;
        end

        if (fall) begin
            d.low_cnt = {{(CW-1){1'b0}}, 1'b1};
            d.armed   = idle;
        end else if (!lvl_i) begin
            if (q.low_cnt < RST_L) begin
                d.low_cnt = q.low_cnt + 1'b1;
                if (q.low_cnt == RST_M1) begin
                    d.vld = 1'b1;
                    d.typ = SYM_RESET;
                end
            end
        end

        if (rise && (q.low_cnt < RST_L)) begin
            if (q.low_cnt >= AT_L) begin
                d.vld = 1'b1;
                d.typ = SYM_RESET;
            end else if (q.armed && (q.low_cnt >= GL_L)) begin
                d.vld = 1'b1;
                if (q.low_cnt < B0_L)      d.typ = SYM_D0;
                else if (q.low_cnt < B1_L) d.typ = SYM_D1;
                else if (q.low_cnt < ST_L) d.typ = SYM_START;
                else                       d.typ = SYM_ATTN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.lvl_prev <= 1'b1;
            q.armed    <= 1'b0;
            q.vld      <= 1'b0;
            q.typ      <= SYM_D0;
            q.low_cnt  <= '0;
            q.high_cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign sym_valid_o  = q.vld;
    assign sym_type_o   = q.typ;
    assign bus_idle_o   = idle;
    assign fall_start_o = fall & idle;

    // R4: a strobe lasts exactly one cycle
    p_one_cycle_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |=> !sym_valid_o);

    // R4: non-Reset symbols are reported right after a rising edge of the filtered level
    p_strobe_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_o && (sym_type_o != 3'(SYM_RESET))) |-> ($past(lvl_i) && !$past(lvl_i, 2)));

    // R2: the bus is never idle unless the level was high in the previous cycle
    p_idle_needs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle_o |-> $past(lvl_i));

endmodule

// File: rtl/pwbus_tx.sv
module pwbus_tx #(
    parameter int CW      = 17,
    parameter int RD1_CYC = 8250,
    parameter int AT_CYC  = 49000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle_i,
    input  logic fall_start_i,
    input  logic rd_one_i,
    input  logic attn_req_i,
    output logic drive_o
);
    localparam logic [CW-1:0] RD1_L = CW'(RD1_CYC);
    localparam logic [CW-1:0] AT_L  = CW'(AT_CYC);
    localparam logic [CW-1:0] ONE   = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          drive;
        logic          pend;
        logic [CW-1:0] cnt;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d      = q;
        d.pend = q.pend | attn_req_i;
        if (q.drive) begin
            if (q.cnt == ONE) begin
                d.drive = 1'b0;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (d.pend && (bus_idle_i || fall_start_i)) begin
            d.drive = 1'b1;
            d.cnt   = AT_L;
            d.pend  = 1'b0;
        end else if (fall_start_i && rd_one_i) begin
            d.drive = 1'b1;
            d.cnt   = RD1_L;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.drive <= 1'b0;
            q.pend  <= 1'b0;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign drive_o = q.drive;

    // R10: drive only begins on an idle bus or at a detected master edge
    p_drive_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_o) |-> $past(bus_idle_i || fall_start_i));

    // R8: a drive is never a single-cycle blip
    p_drive_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_o) |=> drive_o);

endmodule

// File: rtl/pwbus_phy.sv
module pwbus_phy #(
    parameter int CYC_PER_US   = 250,
    parameter int FILT_LEN     = 3,
    parameter int INACT_US     = 11,
    parameter int GLITCH_US    = 8,
    parameter int BIT0_LIM_US  = 26,
    parameter int BIT1_LIM_US  = 62,
    parameter int START_LIM_US = 135,
    parameter int ATTN_LIM_US  = 290,
    parameter int RESET_US     = 354,
    parameter int RD1_US       = 33,
    parameter int ATTN_US      = 196
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       rd_one,
    input  logic       attn_req,
    output logic       drive_low,
    output logic       sym_valid,
    output logic [2:0] sym_type,
    output logic       bus_idle
);
    localparam int INACT_CYC  = INACT_US * CYC_PER_US;
    localparam int GLITCH_CYC = GLITCH_US * CYC_PER_US;
    localparam int B0_CYC     = BIT0_LIM_US * CYC_PER_US;
    localparam int B1_CYC     = BIT1_LIM_US * CYC_PER_US;
    localparam int ST_CYC     = START_LIM_US * CYC_PER_US;
    localparam int ATL_CYC    = ATTN_LIM_US * CYC_PER_US;
    localparam int RESET_CYC  = RESET_US * CYC_PER_US;
    localparam int RD1_CYC    = RD1_US * CYC_PER_US;
    localparam int ATTN_CYC   = ATTN_US * CYC_PER_US;
    localparam int CW         = $clog2(RESET_CYC + 1);

    logic lvl;
    logic fall_start;

    pwbus_filt #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_in),
        .lvl_o  (lvl)
    );

    pwbus_rx #(
        .CW         (CW),
        .INACT_CYC  (INACT_CYC),
        .GLITCH_CYC (GLITCH_CYC),
        .B0_CYC     (B0_CYC),
        .B1_CYC     (B1_CYC),
        .ST_CYC     (ST_CYC),
        .AT_CYC     (ATL_CYC),
        .RST_CYC    (RESET_CYC)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_i        (lvl),
        .sym_valid_o  (sym_valid),
        .sym_type_o   (sym_type),
        .bus_idle_o   (bus_idle),
        .fall_start_o (fall_start)
    );

    pwbus_tx #(
        .CW      (CW),
        .RD1_CYC (RD1_CYC),
        .AT_CYC  (ATTN_CYC)
    ) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_idle_i   (bus_idle),
        .fall_start_i (fall_start),
        .rd_one_i     (rd_one),
        .attn_req_i   (attn_req),
        .drive_o      (drive_low)
    );

    // R7: Reset is reported while the wire is low, or else at the release of a long pulse
    p_reset_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && (sym_type == 3'd4)) |-> ($past(!lvl) || !$past(lvl, 2)));

endmodule

// File: tb/pwbus_phy_test.sv
module pwbus_phy_test;
    localparam int CPU      = 2;
    localparam int FILT     = 3;
    localparam int INACT    = 11 * CPU;
    localparam int GLITCH   = 8 * CPU;
    localparam int B0       = 26 * CPU;
    localparam int B1       = 62 * CPU;
    localparam int STL      = 135 * CPU;
    localparam int ATL      = 290 * CPU;
    localparam int RSTC     = 354 * CPU;
    localparam int RD1C     = 33 * CPU;
    localparam int ATTNC    = 196 * CPU;
    localparam int DETECT   = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic rd_one = 1'b0;
    logic attn_req = 1'b0;
    logic drive_low, sym_valid, bus_idle;
    logic [2:0] sym_type;
    logic line;

    assign line = !(m_low | drive_low);

    always #2 clk = ~clk;

    pwbus_phy #(.CYC_PER_US(CPU), .FILT_LEN(FILT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line),
        .rd_one    (rd_one),
        .attn_req  (attn_req),
        .drive_low (drive_low),
        .sym_valid (sym_valid),
        .sym_type  (sym_type),
        .bus_idle  (bus_idle)
    );

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    int n_strb = 0, last_type = -1;
    int low_len = 0, high_run = 0;
    bit fall_idle = 0, prev_line = 1, prev_vld = 0, prev_drv = 0, prev_m = 0;
    int drv_len = 0, last_drv = 0, drv_events = 0;
    int cyc = 0, m_fall_cyc = 0, drv_lat = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int classify(input int len);
        if (len < B0) return 0;
        if (len < B1) return 1;
        if (len < STL) return 2;
        return 3;
    endfunction

    // behavioural reference model of the wire, compared on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (m_low && !prev_m) m_fall_cyc = cyc;
            prev_m = m_low;
            if (drive_low && !prev_drv) drv_lat = cyc - m_fall_cyc;
            if (drive_low) drv_len++;
            else if (prev_drv) begin
                last_drv = drv_len;
                drv_len = 0;
                drv_events++;
            end
            prev_drv = drive_low;

            if (!line) begin
                if (prev_line) begin
                    fall_idle = (high_run >= INACT);
                    low_len = 0;
                end
                low_len++;
                if (low_len == RSTC) exp_q.push_back(4);
            end else begin
                if (!prev_line && low_len >= FILT) begin
                    if (low_len < RSTC) begin
                        if (low_len >= ATL) exp_q.push_back(4);
                        else if (fall_idle && low_len >= GLITCH) exp_q.push_back(classify(low_len));
                    end
                    high_run = 0;
                end
                high_run++;
            end
            prev_line = line;

            if (sym_valid) begin
                n_strb++;
                last_type = int'(sym_type);
                check(!prev_vld, "R4", 1, 0);
                if (exp_q.size() == 0) check(1'b0, "R5/R6 unexpected strobe", int'(sym_type), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(sym_type) == e, "R3", int'(sym_type), e);
                end
            end
            prev_vld = sym_valid;
        end
    end

    task automatic mpulse(input int n);
        @(posedge clk); #1 m_low = 1'b1;
        repeat (n) @(posedge clk);
        #1 m_low = 1'b0;
    endtask

    task automatic settle(input int wait_n, input string req, input int base, input int exp_n);
        repeat (wait_n) @(posedge clk);
        @(negedge clk);
        check(n_strb - base == exp_n, req, n_strb - base, exp_n);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int b, de;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(drive_low == 0, "R1", drive_low, 0);
        check(sym_valid == 0, "R1", sym_valid, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(bus_idle == 0, "R1", bus_idle, 0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(bus_idle == 1, "R2", bus_idle, 1);

        // R3: each class from an idle bus
        b = n_strb; mpulse(28);  settle(60, "R3 d0", b, 1);
        check(last_type == 0, "R3", last_type, 0);
        b = n_strb; mpulse(84);  settle(60, "R3 d1", b, 1);
        check(last_type == 1, "R3", last_type, 1);
        b = n_strb; mpulse(190); settle(60, "R3 start", b, 1);
        check(last_type == 2, "R3", last_type, 2);
        b = n_strb; mpulse(400); settle(60, "R3 attn", b, 1);
        check(last_type == 3, "R3", last_type, 3);
        b = n_strb; mpulse(640); settle(60, "R3 reset-range", b, 1);
        check(last_type == 4, "R3", last_type, 4);

        // R7: long reset reported while low, bus not idle meanwhile (R2)
        b = n_strb;
        @(posedge clk); #1 m_low = 1'b1;
        repeat (720) @(posedge clk);
        @(negedge clk);
        check(bus_idle == 0, "R2", bus_idle, 0);
        check(n_strb - b == 1, "R7", n_strb - b, 1);
        repeat (40) @(posedge clk);
        #1 m_low = 1'b0;
        settle(60, "R7", b, 1);

        // R5: short low gives no symbol
        b = n_strb; mpulse(10); settle(60, "R5", b, 0);

        // R12: filter glitch
        b = n_strb; mpulse(2);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(bus_idle == 1, "R12", bus_idle, 1);
        settle(40, "R12", b, 0);

        // R6: pulse starting before idle
        b = n_strb; mpulse(28); repeat (10) @(posedge clk); mpulse(84);
        settle(60, "R6", b, 1);
        b = n_strb; mpulse(28); repeat (10) @(posedge clk); mpulse(760);
        settle(60, "R6 reset", b, 2);

        // R9: read of 0
        de = drv_events;
        b = n_strb; rd_one = 1'b0; mpulse(28); settle(60, "R9", b, 1);
        check(drv_events == de, "R9", drv_events - de, 0);

        // R8: read of 1
        de = drv_events;
        b = n_strb; rd_one = 1'b1; mpulse(28);
        #1 rd_one = 1'b0;
        settle(100, "R8", b, 1);
        check(drv_events == de + 1, "R8", drv_events - de, 1);
        check(last_drv == RD1C, "R8", last_drv, RD1C);
        check(drv_lat <= DETECT, "R8", drv_lat, DETECT);
        check(last_type == 1, "R8", last_type, 1);

        // R10: attention from idle
        b = n_strb;
        @(posedge clk); #1 attn_req = 1'b1;
        @(posedge clk); #1 attn_req = 1'b0;
        settle(460, "R10", b, 1);
        check(last_drv == ATTNC, "R10", last_drv, ATTNC);
        check(last_type == 3, "R10", last_type, 3);

        // R11: attention overlapping a master read pulse with rd_one set
        b = n_strb;
        @(posedge clk); #1 m_low = 1'b1; rd_one = 1'b1;
        @(posedge clk); #1 attn_req = 1'b1;
        @(posedge clk); #1 attn_req = 1'b0;
        repeat (26) @(posedge clk);
        #1 m_low = 1'b0; rd_one = 1'b0;
        settle(460, "R11", b, 1);
        check(last_drv == ATTNC, "R11", last_drv, ATTNC);
        check(drv_lat <= DETECT, "R11", drv_lat, DETECT);
        check(last_type == 3, "R11", last_type, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule